// File: doc/BRIEF.md
# Per-Processor GPIO Interrupt Mask Router

This block sits between the line-conditioning logic of a 32-line general-purpose I/O bank and the interrupt controllers of up to four processors. Two vectors arrive from upstream every cycle: a one-cycle pulse for each detected line edge, and the current polarity-corrected level of each line. Each processor owns its own edge-cause register, edge-mask register and level-mask register. A line raises an interrupt term for a processor when its level is high and level-enabled for that processor, or when its edge cause is pending and edge-enabled for that processor. The terms of each processor are ORed in groups of eight lines, which gives four interrupt wires per processor.

Every edge event is recorded in all the cause registers at once. Each processor clears only its own copy, by writing zeros to the bits it wants to acknowledge. A mode input switches the block into a reduced two-processor arrangement. In that mode one shared cause register serves both processors, the masks move to a different set of word addresses, and the outputs of processors 2 and 3 stay low. Software reaches the registers through a simple word-write port with combinational read data.

Top module: `gpio_irq_route`

## Requirements
- R1: After synchronous reset every cause and mask register reads 0 and every bit of `irq_out` is 0.
- R2: With `dual_mode`=0, the cause register of processor n is at byte address 4n, its edge mask is at 0x10+4n and its level mask is at 0x20+4n (n = 0..3). Address bits [1:0] are ignored.
- R3: With `dual_mode`=1, the shared cause is at 0x14 (this is the processor 0 cause register), processor 0 edge and level masks are at 0x18 and 0x1C, and processor 1 edge and level masks are at 0x30 and 0x34. These are the same mask registers that four-processor mode reaches at 0x10, 0x20, 0x14 and 0x24. An address that is not mapped in the current mode reads 0, and a write to it changes no register.
- R4: A 1 on bit i of `edge_evt` in a cycle sets bit i of every processor's cause register at the next clock edge. The bit stays set until it is cleared.
- R5: A write to a cause register clears each bit where `bus_wdata` is 0 and keeps each bit where it is 1. An edge event in the same cycle as a clearing write leaves that bit set.
- R6: The term of line i for processor c is (`line_lvl`[i] AND lmask_c[i]) OR (cause_c[i] AND emask_c[i]). A line whose masks are both 0 has no effect on any output.
- R7: `irq_out`[4c+g] is the OR of the terms of processor c for lines 8g..8g+7. It follows `line_lvl` in the same cycle and follows a cause bit in the cycle after the edge that set it.
- R8: With `dual_mode`=1, `irq_out`[15:8] (processors 2 and 3) is 0, and processor 1 uses the shared cause register in place of its own.
- R9: In four-processor mode, a clearing write to one processor's cause register leaves the cause registers of the other processors unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dual_mode | input | 1 | 1 selects the two-processor layout, 0 the four-processor layout |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| edge_evt | input | 32 | One-cycle pulse for each line that saw an edge |
| line_lvl | input | 32 | Polarity-corrected line levels |
| irq_out | output | 16 | Grouped interrupt wires, bit 4c+g = processor c, line group g |

## Verification
The bench targets the aliasing between the two address layouts. A decoder that maps the dual-mode masks to the wrong registers would read back values written under the other layout, or would accept a write to an unmapped word. It checks the zero-to-clear rule both ways: a write of all ones must keep the pending bits, and a clear in the same cycle as an edge must lose to the edge. A design that used write-one-to-clear, or that let the write win, returns a different cause value. It also shows that processor 1 in dual mode reacts to the shared cause while its own copy is clear, and that processors 2 and 3 go silent even though their level masks still enable an active line.

// File: rtl/gpio_irq_route_pkg.sv
package gpio_irq_route_pkg;

    localparam int NUM_CPU  = 4;
    localparam int LINES    = 32;
    localparam int GRP_SIZE = 8;
    localparam int ADDR_W   = 6;
    localparam int NUM_GRP  = LINES / GRP_SIZE;
    localparam int CPU_W    = $clog2(NUM_CPU);
    localparam int WORD_W   = ADDR_W - 2;

    // word indices (byte address / 4)
    localparam int QUAD_EM_BASE = 4;
    localparam int QUAD_LM_BASE = 8;
    localparam int DUAL_CAUSE   = 5;
    localparam int DUAL_EM0     = 6;
    localparam int DUAL_LM0     = 7;
    localparam int DUAL_EM1     = 12;
    localparam int DUAL_LM1     = 13;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_CAUSE = 2'd1,
        SEL_EMASK = 2'd2,
        SEL_LMASK = 2'd3
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e           sel;
        logic [CPU_W-1:0]   cpu;
    } reg_hit_t;

    function automatic reg_hit_t decode_word(input logic dual, input logic [WORD_W-1:0] w);
        reg_hit_t h;
        int       wi;
        wi    = int'(w);
        h.sel = SEL_NONE;
        h.cpu = '0;
        if (dual) begin
            if (wi == DUAL_CAUSE) begin
                h.sel = SEL_CAUSE;
            end else if (wi == DUAL_EM0) begin
                h.sel = SEL_EMASK;
            end else if (wi == DUAL_LM0) begin
                h.sel = SEL_LMASK;
            end else if (wi == DUAL_EM1) begin
                h.sel = SEL_EMASK;
                h.cpu = CPU_W'(1);
            end else if (wi == DUAL_LM1) begin
                h.sel = SEL_LMASK;
                h.cpu = CPU_W'(1);
            end
        end else begin
            if (wi < NUM_CPU) begin
                h.sel = SEL_CAUSE;
                h.cpu = CPU_W'(wi);
            end else if (wi >= QUAD_EM_BASE && wi < QUAD_EM_BASE + NUM_CPU) begin
                h.sel = SEL_EMASK;
                h.cpu = CPU_W'(wi - QUAD_EM_BASE);
            end else if (wi >= QUAD_LM_BASE && wi < QUAD_LM_BASE + NUM_CPU) begin
                h.sel = SEL_LMASK;
                h.cpu = CPU_W'(wi - QUAD_LM_BASE);
            end
        end
        return h;
    endfunction

endpackage

// File: rtl/gpio_irq_cfg_regs.sv
module gpio_irq_cfg_regs
    import gpio_irq_route_pkg::*;
#(
    parameter int N_CPU  = NUM_CPU,
    parameter int N_LINE = LINES,
    parameter int AW     = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dual_mode,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [N_LINE-1:0] wdata,
    input  logic [N_LINE-1:0] edge_evt,
    output logic [N_LINE-1:0] rdata,
    output logic [N_LINE-1:0] cause_q [N_CPU],
    output logic [N_LINE-1:0] emask_q [N_CPU],
    output logic [N_LINE-1:0] lmask_q [N_CPU]
);

    reg_hit_t hit;

    assign hit = decode_word(dual_mode, addr[AW-1:2]);

    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
        logic sel_me;
        assign sel_me = wr_en && (int'(hit.cpu) == c);

        always_ff @(posedge clk) begin
            if (rst) begin
                cause_q[c] <= '0;
                emask_q[c] <= '0;
                lmask_q[c] <= '0;
            end else begin
                // zero-to-clear, with a coincident edge taking priority
                if (sel_me && hit.sel == SEL_CAUSE) begin
                    cause_q[c] <= (cause_q[c] & wdata) | edge_evt;
                end else begin
                    cause_q[c] <= cause_q[c] | edge_evt;
                end
                if (sel_me && hit.sel == SEL_EMASK) begin
                    emask_q[c] <= wdata;
                end
                if (sel_me && hit.sel == SEL_LMASK) begin
                    lmask_q[c] <= wdata;
                end
            end
        end
    end

    always_comb begin
        unique case (hit.sel)
            SEL_CAUSE: rdata = cause_q[hit.cpu];
            SEL_EMASK: rdata = emask_q[hit.cpu];
            SEL_LMASK: rdata = lmask_q[hit.cpu];
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_irq_cpu_route.sv
module gpio_irq_cpu_route
    import gpio_irq_route_pkg::*;
#(
    parameter int N_LINE = LINES,
    parameter int GSIZE  = GRP_SIZE
) (
    input  logic              active,
    input  logic [N_LINE-1:0] level,
    input  logic [N_LINE-1:0] cause,
    input  logic [N_LINE-1:0] emask,
    input  logic [N_LINE-1:0] lmask,
    output logic [N_LINE/GSIZE-1:0] grp_irq
);

    localparam int NG = N_LINE / GSIZE;

    logic [N_LINE-1:0] term;

    assign term = (level & lmask) | (cause & emask);

    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign grp_irq[g] = active & (|term[g*GSIZE +: GSIZE]);
    end

endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route
    import gpio_irq_route_pkg::*;
#(
    parameter int N_CPU  = NUM_CPU,
    parameter int N_LINE = LINES,
    parameter int GSIZE  = GRP_SIZE,
    parameter int AW     = ADDR_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       dual_mode,
    input  logic                       bus_wr,
    input  logic [AW-1:0]              bus_addr,
    input  logic [N_LINE-1:0]          bus_wdata,
    output logic [N_LINE-1:0]          bus_rdata,
    input  logic [N_LINE-1:0]          edge_evt,
    input  logic [N_LINE-1:0]          line_lvl,
    output logic [N_CPU*(N_LINE/GSIZE)-1:0] irq_out
);

    localparam int NG = N_LINE / GSIZE;

    logic [N_LINE-1:0] cause_q [N_CPU];
    logic [N_LINE-1:0] emask_q [N_CPU];
    logic [N_LINE-1:0] lmask_q [N_CPU];

    gpio_irq_cfg_regs #(
        .N_CPU (N_CPU),
        .N_LINE(N_LINE),
        .AW    (AW)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .dual_mode(dual_mode),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .edge_evt (edge_evt),
        .rdata    (bus_rdata),
        .cause_q  (cause_q),
        .emask_q  (emask_q),
        .lmask_q  (lmask_q)
    );

    for (genvar c = 0; c < N_CPU; c++) begin : g_route
        logic              active;
        logic [N_LINE-1:0] cause_sel;

        // in the two-processor layout every processor sees the shared register
        assign cause_sel = dual_mode ? cause_q[0] : cause_q[c];
        assign active    = !dual_mode || (c < 2);

        gpio_irq_cpu_route #(
            .N_LINE(N_LINE),
            .GSIZE (GSIZE)
        ) u_cpu (
            .active (active),
            .level  (line_lvl),
            .cause  (cause_sel),
            .emask  (emask_q[c]),
            .lmask  (lmask_q[c]),
            .grp_irq(irq_out[c*NG +: NG])
        );
    end

endmodule

// File: rtl/gpio_irq_route_chk.sv
module gpio_irq_route_chk
    import gpio_irq_route_pkg::*;
#(
    parameter int N_CPU  = NUM_CPU,
    parameter int N_LINE = LINES,
    parameter int GSIZE  = GRP_SIZE
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            dual_mode,
    input logic [N_LINE-1:0]               edge_evt,
    input logic [N_CPU*(N_LINE/GSIZE)-1:0] irq_out,
    input logic [N_LINE-1:0]               cause_q [N_CPU],
    input logic [N_LINE-1:0]               emask_q [N_CPU],
    input logic [N_LINE-1:0]               lmask_q [N_CPU]
);

    localparam int NG = N_LINE / GSIZE;

    for (genvar c = 0; c < N_CPU; c++) begin : g_chk
        // R4: every edge lands in every processor's cause register
        assert_edge_latch_R4: assert property (@(posedge clk) disable iff (rst)
            (edge_evt != '0) |=> ((cause_q[c] & $past(edge_evt)) == $past(edge_evt)));

        // R5: a cause bit never becomes set without an edge
        assert_no_spurious_set_R5: assert property (@(posedge clk) disable iff (rst)
            (cause_q[c] != '1) |=> ((cause_q[c] & ~$past(cause_q[c]) & ~$past(edge_evt)) == '0));

        // R6: a processor with all lines masked stays quiet
        assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (rst)
            (emask_q[c] == '0 && lmask_q[c] == '0) |-> (irq_out[c*NG +: NG] == '0));
    end

    // R8: processors 2 and 3 are silent in the two-processor layout
    assert_unused_low_R8: assert property (@(posedge clk) disable iff (rst)
        dual_mode |-> ((irq_out >> (2*NG)) == '0));

endmodule

bind gpio_irq_route gpio_irq_route_chk #(
    .N_CPU (N_CPU),
    .N_LINE(N_LINE),
    .GSIZE (GSIZE)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .dual_mode(dual_mode),
    .edge_evt (edge_evt),
    .irq_out  (irq_out),
    .cause_q  (cause_q),
    .emask_q  (emask_q),
    .lmask_q  (lmask_q)
);

// File: tb/gpio_irq_route_tb.sv
module gpio_irq_route_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dual_mode = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] edge_evt = '0;
    logic [31:0] line_lvl = '0;
    logic [15:0] irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_rd;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #10 clk = ~clk;

    gpio_irq_route u_dut (
        .clk      (clk),
        .rst      (rst),
        .dual_mode(dual_mode),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .edge_evt (edge_evt),
        .line_lvl (line_lvl),
        .irq_out  (irq_out)
    );

    // monitor: compares queued expectations mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                sb_item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = it.is_rd ? bus_rdata : {16'h0, irq_out};
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s %s actual=%h expected=%h",
                             it.tag, it.is_rd ? "rdata" : "irq", act, it.exp);
                end
            end
        end
    end

    // driver: one cycle per call, pulses cleared by default
    task automatic step();
        @(posedge clk);
        #2;
        bus_wr   = 1'b0;
        edge_evt = '0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        step();
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic wr_edge(input logic [5:0] a, input logic [31:0] d, input logic [31:0] e);
        step();
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; edge_evt = e;
    endtask

    task automatic pulse(input logic [31:0] e);
        step();
        edge_evt = e;
    endtask

    task automatic set_level(input logic [31:0] v);
        step();
        line_lvl = v;
    endtask

    task automatic set_mode(input logic m);
        step();
        dual_mode = m;
    endtask

    task automatic chk_rd(input logic [5:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        step();
        bus_addr = a;
        it.is_rd = 1'b1; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic chk_irq(input logic [15:0] e, input string tag);
        sb_item_t it;
        step();
        it.is_rd = 1'b0; it.exp = {16'h0, e}; it.tag = tag;
        sb_q.push_back(it);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;

        // R1 reset state
        chk_irq(16'h0000, "R1 irq after reset");
        chk_rd(6'h10, 32'h0, "R1 emask0 after reset");
        chk_rd(6'h00, 32'h0, "R1 cause0 after reset");

        // R6 / R7 level path, four-processor layout
        wr(6'h20, 32'h0000_00FF);
        set_level(32'h0000_0001);
        chk_irq(16'h0001, "R6 level cpu0 grp0");
        set_level(32'h0100_0000);
        chk_irq(16'h0000, "R6 masked line no effect");
        wr(6'h28, 32'hFF00_0000);
        chk_irq(16'h0800, "R7 cpu2 grp3");
        set_level(32'h0100_0001);
        chk_irq(16'h0801, "R7 two cpus independent");
        set_level(32'h0);
        chk_irq(16'h0000, "R7 level dropped");
        chk_rd(6'h28, 32'hFF00_0000, "R2 lmask2 address");

        // R4 edge latched for all processors
        wr(6'h14, 32'h0000_FF00);
        pulse(32'h0000_0200);
        chk_irq(16'h0020, "R4 cpu1 grp1 from edge");
        chk_rd(6'h00, 32'h0000_0200, "R4 cause0 latched");
        chk_rd(6'h0C, 32'h0000_0200, "R4 cause3 latched");

        // R5 zero-to-clear, R9 independence
        wr(6'h04, 32'hFFFF_FFFF);
        chk_rd(6'h04, 32'h0000_0200, "R5 ones keep pending");
        wr(6'h04, ~32'h0000_0200);
        chk_rd(6'h04, 32'h0, "R5 zero clears");
        chk_irq(16'h0000, "R5 irq drops after clear");
        chk_rd(6'h00, 32'h0000_0200, "R9 cause0 untouched");
        chk_rd(6'h08, 32'h0000_0200, "R9 cause2 untouched");
        wr_edge(6'h00, 32'h0, 32'h0000_0004);
        chk_rd(6'h00, 32'h0000_0004, "R5 edge wins over clear");
        wr(6'h04, 32'h0);
        chk_rd(6'h04, 32'h0, "R5 cause1 cleared");

        // R8 / R3 two-processor layout
        set_mode(1'b1);
        set_level(32'h0100_0000);
        chk_irq(16'h0000, "R8 cpu2 silent in dual");
        set_level(32'h0);
        chk_rd(6'h14, 32'h0000_0004, "R3 shared cause address");
        chk_rd(6'h00, 32'h0, "R3 unmapped reads zero");
        wr(6'h30, 32'h0000_0004);
        chk_irq(16'h0010, "R8 cpu1 uses shared cause");
        wr(6'h18, 32'h0000_0004);
        chk_irq(16'h0011, "R3 dual emask0");
        wr(6'h14, 32'h0);
        chk_irq(16'h0000, "R5 shared cause cleared");
        wr(6'h34, 32'h0000_8000);
        set_level(32'h0000_8000);
        chk_irq(16'h0020, "R3 dual lmask1");
        set_level(32'h0);
        wr(6'h24, 32'hFFFF_FFFF);

        // back to four-processor layout: aliasing and ignored write
        set_mode(1'b0);
        chk_rd(6'h24, 32'h0000_8000, "R3 unmapped write ignored");
        chk_rd(6'h10, 32'h0000_0004, "R3 em0 alias");
        chk_rd(6'h18, 32'h0, "R2 emask2 untouched");
        chk_rd(6'h14, 32'h0000_0004, "R3 em1 alias");

        step();
        step();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule